// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Bottom-Loaded Compare Buffers

This block is a 16-bit timer that counts up to a selectable top value, holds that value for one clock, and then counts back down to zero. Two compare channels watch the count. Each channel drives a PWM pin that changes level on a compare match, and the level it takes depends on the direction of the count. Because the count rises and falls, the pulses are centred in the period.

The top value comes from a period register or from the active compare value of channel A, depending on the mode input. Software writes compare values into per-channel buffers. The buffers are copied into the active compare registers only on the clock where the count is zero. A new duty cycle, or a new period in compare-A mode, therefore always starts on a full period and both halves of the period stay equal. Four event flags record bottom, top, and the two compare matches. Writing a one to a flag bit clears that flag.

The count advances on every clock. Top values below 3 are outside the legal range of 3 to 0xFFFF.

Top module: `pwm_dual_slope_top`

## Requirements
- R1: After reset the count is 0 and counting up. The count rises by one per clock while it is below top. On the clock where the rising count is at or above top, it turns and falls by one per clock. On the clock where the count is 0 while falling, it turns and rises again. The count therefore holds the top value for exactly one clock and the value 0 for exactly one clock.
- R2: When mode_i equals 9, the top value is the active compare value of channel A. For any other mode value, the top value is the period register.
- R3: The bus decodes wr_sel_i as follows: 0 writes the channel A buffer, 1 writes the channel B buffer, 2 writes the period register (effective on the next clock), and 3 clears flags. A buffer value becomes active only at the end of a clock where the count is 0. A buffer write made during that same clock waits for the next bottom.
- R4: Flag bit 0 (bottom) sets on the clock after a clock where the count is 0. This is the same edge at which the active compare values load from their buffers.
- R5: Flag bit 1 (top) sets after the turning clock at top, but only when mode_i is not 9. In mode 9, the top event shows up as the channel A match flag.
- R6: Flag bits 2 and 3 set after any clock where the count equals the active compare value of channel A or channel B, respectively.
- R7: Each output mode is 2 bits. Mode 2 drives the pin low on a match while rising and high on a match while falling. Mode 3 drives the opposite levels. Modes 0 and 1 hold the pin at 0. The pin is registered and changes one clock after the match.
- R8: A write with wr_sel_i = 3 clears every flag whose wr_data_i bit is 1. If a set event happens in the same clock as the clear, the flag stays set.
- R9: Under reset, the count, flags, pins, buffers, active compare values and period register are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 4 | Top source select (9 = channel A compare, other = period) |
| com_a_i | input | 2 | Output mode of channel A |
| com_b_i | input | 2 | Output mode of channel B |
| wr_en_i | input | 1 | Bus write strobe |
| wr_sel_i | input | 2 | Bus write target |
| wr_data_i | input | 16 | Bus write data |
| count_o | output | 16 | Current count |
| flags_o | output | 4 | Flags: bottom, top, match A, match B (bits 0 to 3) |
| pwm_a_o | output | 1 | Channel A PWM pin |
| pwm_b_o | output | 1 | Channel B PWM pin |

## Verification
Two kinds of events can fall in the same clock. A buffer write can land on the bottom clock, where the buffers are also being copied to the active registers. A flag clear can land on a clock where that flag is also being set. The bench provokes both cases on purpose: it waits until count_o reads 0 and then issues the write or the clear in that clock. It also scatters clears at random offsets. A behavioural reference model tracks the count, the flags and both pins every clock. The expected outcome is that the active value changes only at the following bottom, and that a set event wins over a clear.

// File: rtl/pwm_tmr_pkg.sv
// Shared constants and bus target encoding for the dual-slope PWM timer.
package pwm_tmr_pkg;
    localparam int FLAG_N       = 4;
    localparam int FLAG_BOT     = 0;
    localparam int FLAG_TOP     = 1;
    localparam int FLAG_MA      = 2;
    localparam int FLAG_MB      = 3;
    localparam logic [3:0] MODE_TOP_CMPA = 4'd9;

    typedef enum logic [1:0] {
        SEL_BUF_A   = 2'd0,
        SEL_BUF_B   = 2'd1,
        SEL_PERIOD  = 2'd2,
        SEL_FLAG_CLR = 2'd3
    } bus_sel_t;
endpackage

// File: rtl/pwm_updown_cnt.sv
// Up/down counter that reverses at a supplied top and at zero.
// Assumes top_i is stable over the turning clock; tops below 3 are illegal
// but are handled without wrapping.
module pwm_updown_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] top_i,
    output logic [W-1:0] cnt_o,
    output logic         up_o,
    output logic         at_top_o,
    output logic         at_bot_o
);
    logic [W-1:0] cnt_q;
    logic         up_q;

    // Decode turning points from the current state.
    always_comb begin
        at_top_o = up_q && (cnt_q >= top_i);
        at_bot_o = (cnt_q == '0);
    end

    // Advance the count and flip direction at either end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (up_q) begin
            if (cnt_q >= top_i) begin
                up_q  <= 1'b0;
                cnt_q <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (cnt_q == '0) begin
            up_q  <= 1'b1;
            cnt_q <= (top_i == '0) ? '0 : {{(W-1){1'b0}}, 1'b1};
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o = cnt_q;
    assign up_o  = up_q;

    AST_TOP_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && cnt_q == top_i && cnt_q != '0) |=> (!up_q && cnt_q + 1'b1 == $past(cnt_q))); // R1
    AST_BOT_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_q && cnt_q == '0 && top_i != '0) |=> (up_q && cnt_q == {{(W-1){1'b0}}, 1'b1})); // R1
    AST_RISE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && cnt_q < top_i) |=> (up_q && cnt_q == $past(cnt_q) + 1'b1)); // R1
endmodule

// File: rtl/pwm_cmp_chan.sv
// One compare channel: bus-side buffer, active compare loaded at bottom,
// match detect and registered PWM pin. Assumes load_i pulses on bottom clocks.
module pwm_cmp_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         load_i,
    input  logic [W-1:0] cnt_i,
    input  logic         cnt_up_i,
    input  logic [1:0]   com_i,
    output logic [W-1:0] active_o,
    output logic         match_o,
    output logic         pwm_o
);
    logic [W-1:0] buf_q;
    logic [W-1:0] act_q;
    logic         pwm_q;

    // Capture bus writes into the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)    buf_q <= '0;
        else if (wr_i) buf_q <= wr_data_i;
    end

    // Copy the buffer into the active compare at bottom.
    always_ff @(posedge clk) begin
        if (!rst_n)      act_q <= '0;
        else if (load_i) act_q <= buf_q;
    end

    assign match_o = (cnt_i == act_q);

    // Drive the pin from the match and count direction.
    always_ff @(posedge clk) begin
        if (!rst_n)              pwm_q <= 1'b0;
        else if (!com_i[1])      pwm_q <= 1'b0;
        else if (match_o)        pwm_q <= (~cnt_up_i) ^ com_i[0];
    end

    assign active_o = act_q;
    assign pwm_o    = pwm_q;

    AST_LOAD_AT_BOT: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (act_q == $past(buf_q))); // R3
    AST_HOLD_OFF_BOT: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(act_q)); // R3
    AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !com_i[1] |=> !pwm_q); // R7
endmodule

// File: rtl/pwm_flag_reg.sv
// Event flags with write-one-to-clear; a set in the same clock wins.
module pwm_flag_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;

    // Clear requested bits, then apply set events on top.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o = flags_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i))); // R8
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((flags_q & $past(clr_i & ~set_i)) == '0)); // R8
endmodule

// File: rtl/pwm_dual_slope_top.sv
// Dual-slope PWM timer: selects top, decodes bus writes, joins counter,
// two compare channels and the flag register. Assumes one count per clock.
module pwm_dual_slope_top
    import pwm_tmr_pkg::*;
#(
    parameter int W  = 16,
    parameter int NCH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   mode_i,
    input  logic [1:0]   com_a_i,
    input  logic [1:0]   com_b_i,
    input  logic         wr_en_i,
    input  logic [1:0]   wr_sel_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] count_o,
    output logic [3:0]   flags_o,
    output logic         pwm_a_o,
    output logic         pwm_b_o
);
    logic [W-1:0]      period_q;
    logic [W-1:0]      top_val;
    logic [W-1:0]      cnt;
    logic              cnt_up;
    logic              at_top;
    logic              at_bot;
    logic              top_is_cmpa;
    logic [1:0]        com_arr   [NCH];
    logic [W-1:0]      act_arr   [NCH];
    logic [NCH-1:0]    match_v;
    logic [NCH-1:0]    pwm_v;
    logic [FLAG_N-1:0] flag_set;
    logic [FLAG_N-1:0] flag_clr;

    assign top_is_cmpa = (mode_i == MODE_TOP_CMPA);
    assign top_val     = top_is_cmpa ? act_arr[0] : period_q;
    assign com_arr[0]  = com_a_i;
    assign com_arr[1]  = com_b_i;

    // Period register takes bus writes directly.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      period_q <= '0;
        else if (wr_en_i && wr_sel_i == SEL_PERIOD)      period_q <= wr_data_i;
    end

    pwm_updown_cnt #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .top_i    (top_val),
        .cnt_o    (cnt),
        .up_o     (cnt_up),
        .at_top_o (at_top),
        .at_bot_o (at_bot)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        pwm_cmp_chan #(.W(W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (wr_en_i && wr_sel_i == 2'(i)),
            .wr_data_i (wr_data_i),
            .load_i    (at_bot),
            .cnt_i     (cnt),
            .cnt_up_i  (cnt_up),
            .com_i     (com_arr[i]),
            .active_o  (act_arr[i]),
            .match_o   (match_v[i]),
            .pwm_o     (pwm_v[i])
        );
    end

    // Gather flag events and bus clear requests.
    always_comb begin
        flag_set           = '0;
        flag_set[FLAG_BOT] = at_bot;
        flag_set[FLAG_TOP] = at_top && !top_is_cmpa;
        flag_set[FLAG_MA]  = match_v[0];
        flag_set[FLAG_MB]  = match_v[1];
        flag_clr = (wr_en_i && wr_sel_i == SEL_FLAG_CLR) ? wr_data_i[FLAG_N-1:0] : '0;
    end

    pwm_flag_reg #(.N(FLAG_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (flag_set),
        .clr_i   (flag_clr),
        .flags_o (flags_o)
    );

    assign count_o = cnt;
    assign pwm_a_o = pwm_v[0];
    assign pwm_b_o = pwm_v[1];

    AST_BOT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0) |=> flags_o[FLAG_BOT]); // R4
    AST_TOP_FLAG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_up && count_o == period_q && count_o != '0 && !top_is_cmpa) |=> flags_o[FLAG_TOP]); // R5
endmodule

// File: tb/sim_pwm_dual_slope_top.sv
// Bench with a behavioural reference model compared every clock.
module sim_pwm_dual_slope_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode_i = 4'd8;
    logic [1:0]  com_a_i = 2'd0;
    logic [1:0]  com_b_i = 2'd0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = 2'd0;
    logic [15:0] wr_data_i = 16'd0;
    logic [15:0] count_o;
    logic [3:0]  flags_o;
    logic        pwm_a_o;
    logic        pwm_b_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit running  = 1'b0;
    bit done     = 1'b0;

    // reference model state
    int m_cnt, m_up, m_bufa, m_bufb, m_acta, m_actb, m_per, m_flags, m_pa, m_pb;

    always #2 clk = ~clk;

    pwm_dual_slope_top u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .com_a_i(com_a_i), .com_b_i(com_b_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .count_o(count_o), .flags_o(flags_o), .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model step, evaluated on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_up = 1; m_bufa = 0; m_bufb = 0; m_acta = 0; m_actb = 0;
            m_per = 0; m_flags = 0; m_pa = 0; m_pb = 0;
        end else begin
            int top, ma, mb, bot, tev, setv, clr, ncnt, nup;
            top  = (mode_i == 4'd9) ? m_acta : m_per;
            ma   = (m_cnt == m_acta);
            mb   = (m_cnt == m_actb);
            bot  = (m_cnt == 0);
            tev  = m_up && (m_cnt >= top);
            setv = (mb << 3) | (ma << 2) | ((tev && mode_i != 4'd9) << 1) | bot;
            clr  = (wr_en_i && wr_sel_i == 2'd3) ? wr_data_i[3:0] : 0;
            if (com_a_i < 2) m_pa = 0; else if (ma) m_pa = m_up ? (com_a_i == 3) : (com_a_i != 3);
            if (com_b_i < 2) m_pb = 0; else if (mb) m_pb = m_up ? (com_b_i == 3) : (com_b_i != 3);
            m_flags = (m_flags & ~clr & 15) | setv;
            if (m_up) begin
                if (m_cnt >= top) begin nup = 0; ncnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
                else begin nup = 1; ncnt = m_cnt + 1; end
            end else if (m_cnt == 0) begin nup = 1; ncnt = (top == 0) ? 0 : 1; end
            else begin nup = 0; ncnt = m_cnt - 1; end
            if (bot) begin m_acta = m_bufa; m_actb = m_bufb; end
            if (wr_en_i && wr_sel_i == 2'd0) m_bufa = wr_data_i;
            if (wr_en_i && wr_sel_i == 2'd1) m_bufb = wr_data_i;
            if (wr_en_i && wr_sel_i == 2'd2) m_per = wr_data_i;
            m_cnt = ncnt; m_up = nup;
        end
    end

    // Compare every output against the model between edges.
    always @(negedge clk) begin
        if (running && rst_n) begin
            check("R1 R2 count", count_o, m_cnt);
            check("R3 R4 R5 R6 R8 flags", flags_o, m_flags);
            check("R7 pwm_a", pwm_a_o, m_pa);
            check("R7 pwm_b", pwm_b_o, m_pb);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_now(input logic [1:0] sel, input logic [15:0] d);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        write_now(sel, d);
    endtask

    task automatic wait_bottom();
        @(negedge clk);
        while (count_o != 16'd0) @(negedge clk);
    endtask

    initial begin
        idle(3);
        // R9: reset state seen at the ports
        check("R9 count", count_o, 0);
        check("R9 flags", flags_o, 0);
        check("R9 pwm_a", pwm_a_o, 0);
        check("R9 pwm_b", pwm_b_o, 0);
        rst_n = 1'b1;
        running = 1'b1;
        com_a_i = 2'd2; com_b_i = 2'd3;
        bus_write(2'd2, 16'd20);
        bus_write(2'd0, 16'd5);
        bus_write(2'd1, 16'd12);
        idle(100);
        // R8: clears at scattered offsets
        for (int i = 0; i < 8; i++) begin
            idle($urandom % 17);
            bus_write(2'd3, 16'hF);
        end
        // R3: buffer write on the bottom clock waits one period
        wait_bottom();
        write_now(2'd0, 16'd9);
        idle(90);
        // R2: top from channel A compare
        mode_i = 4'd9;
        bus_write(2'd0, 16'd10);
        idle(80);
        wait_bottom();
        write_now(2'd0, 16'd6);
        idle(60);
        // R7: idle and swapped output modes
        com_a_i = 2'd0; com_b_i = 2'd1;
        idle(50);
        com_a_i = 2'd3; com_b_i = 2'd2;
        idle(50);
        // R1: minimum legal top
        mode_i = 4'd8;
        bus_write(2'd2, 16'd3);
        bus_write(2'd0, 16'd1);
        bus_write(2'd1, 16'd2);
        idle(40);
        // R8: clear on the same clock as the bottom set
        wait_bottom();
        write_now(2'd3, 16'hF);
        idle(10);
        // R1: period lowered below the running count
        bus_write(2'd2, 16'd40);
        idle(30);
        bus_write(2'd2, 16'd10);
        idle(50);
        running = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule